// File: doc/BRIEF.md
# Time-Aware Queue Gate Controller

This block opens and closes the transmit gates of four queues according to a repeating schedule. The schedule is timed from a free-running time-of-day counter that the block receives as a seconds value and a nanoseconds value. Software supplies the following:

- a base time, as seconds and nanoseconds;
- a cycle length in nanoseconds;
- for each queue, an offset where its window opens and an offset where it closes;
- for each queue, two guard flags.

Once the schedule is armed, a new cycle starts every cycle-length nanoseconds, counted from the base time. Each queue's gate is open while the position inside the current cycle lies within that queue's window.

A transmit engine presents the byte length of its next frame. The block answers, per queue, whether that frame may start now. It converts the length to time on the wire at 3.2 ns per byte, rounded up. With the guard flags it refuses frames that would run past the queue's window end or past the cycle boundary.

If the programmed base time is already in the past when the schedule is armed, the block moves it forward to the next cycle boundary after the arming time. This uses a bit-serial remainder divider. It then carries any excess nanoseconds into the seconds field. All gates stay closed until the resulting start time is reached.

When the schedule is off, the block behaves as an always-open schedule: each window covers 0 to 1,000,000,000 ns of a 1,000,000,000 ns cycle, and no guard flags are set.

Top module: `tgc_gate_ctrl`

## Requirements
- R1: While `sched_en` is low, and during and after reset until arming, every bit of `gate_open` and `may_start` is 1 for any frame length.
- R2: When running, bit i of `gate_open` is 1 exactly when now ≥ E and start_i ≤ P < end_i. Here E is the effective base, P = (now − E) mod cycle, and queue i's offsets are bits [32i+31:32i] of `q_start` and `q_end`.
- R3: Arming happens on the first clock edge where `sched_en` is high, and it samples the time-of-day at that edge (T) together with all configuration inputs. If the base B ≥ T, then E = B; otherwise E = B + (floor((T − B)/cycle) + 1) × cycle.
- R4: Once running, `eff_base_sec`/`eff_base_ns` hold E with the nanoseconds part below 1,000,000,000. Excess nanoseconds, including from a programmed base above that limit, carry into seconds.
- R5: From the second clock after arming until E is reached, all gates are closed and no frame may start.
- R6: When bit i of `strict_end` is set, queue i admits a frame only if P + D ≤ end_i, where D = ceil(length × 3.2) ns.
- R7: When bit i of `strict_cycle` is set, queue i admits a frame only if P + D ≤ cycle.
- R8: The frame duration D is computed as ceil(16 × length / 5) nanoseconds from the byte count on `frame_len`.
- R9: While running, a frame longer than 1600 bytes is refused on every queue.
- R10: A queue never admits a frame while its gate is closed. When neither guard flag is set for a queue and the length is within limit, admission equals that queue's gate.
- R11: Changes to the base, cycle, offsets or flags while armed have no effect. A new schedule is taken only when the block is re-armed after reset or after `sched_en` has been low.
- R12: Outputs are registered. They reflect the time-of-day and frame length sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_sec | input | SEC_W | Time-of-day, seconds |
| tod_ns | input | 30 | Time-of-day, nanoseconds (below 1e9) |
| sched_en | input | 1 | Arms the schedule while high; low returns to the open default |
| base_sec | input | SEC_W | Programmed base time, seconds |
| base_ns | input | 30 | Programmed base time, nanoseconds |
| cycle_ns | input | 32 | Cycle length in ns (nonzero, longer than the time advance of 70 clocks) |
| q_start | input | 32·NQ | Window open offsets, queue i at bits [32i+31:32i] |
| q_end | input | 32·NQ | Window close offsets, same packing |
| strict_cycle | input | NQ | Per-queue guard: frame must finish inside the cycle |
| strict_end | input | NQ | Per-queue guard: frame must finish inside the window |
| frame_len | input | LEN_W | Length in bytes of the frame waiting to start |
| gate_open | output | NQ | Gate state per queue |
| may_start | output | NQ | Frame admission per queue |
| eff_base_sec | output | SEC_W | Effective base time, seconds |
| eff_base_ns | output | 30 | Effective base time, nanoseconds |

## Verification
The bench targets four corner cases of arming and admission:

- **Past base time.** A design that skipped the forward move would compute cycle phase from the stale origin, so every gate edge would be misplaced.
- **Nanoseconds carry.** A forward move whose nanosecond sum crosses one second, and a programmed base whose nanoseconds field is already over the limit, both need a carry. A design that missed it would report an out-of-range nanoseconds value and open gates a second early.
- **Guard flags.** These are driven with frame lengths whose duration straddles the window or cycle end. A wrong duration rounding or a flipped comparison would admit frames that overrun.
- **Configuration changed while running.** A design that stopped holding its latched copy would visibly change its gate pattern.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    localparam logic [31:0] TGC_NS_PER_SEC = 32'd1_000_000_000;

    typedef logic [63:0] tgc_time_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DIV  = 2'd1,
        ST_NORM = 2'd2,
        ST_RUN  = 2'd3
    } tgc_state_e;

    typedef struct packed {
        logic [31:0] start_ofs;
        logic [31:0] end_ofs;
        logic        strict_cyc;
        logic        strict_end;
    } tgc_qcfg_t;

    localparam tgc_qcfg_t TGC_QCFG_DEFAULT = '{
        start_ofs:  32'd0,
        end_ofs:    TGC_NS_PER_SEC,
        strict_cyc: 1'b0,
        strict_end: 1'b0
    };

    // seconds/nanoseconds pair to a flat nanosecond count
    function automatic tgc_time_t tgc_to_ns(input logic [31:0] sec, input logic [31:0] ns);
        return ({32'd0, sec} * 64'd1_000_000_000) + {32'd0, ns};
    endfunction

    // wire time of a frame at 3.2 ns per byte, rounded up
    function automatic logic [31:0] tgc_frame_ns(input logic [15:0] len);
        logic [31:0] scaled;
        scaled = ({16'd0, len} << 4) + 32'd4;
        return scaled / 32'd5;
    endfunction

endpackage

// File: rtl/tgc_qgate.sv
module tgc_qgate
    import tgc_pkg::*;
(
    input  tgc_time_t   phase,
    input  logic [31:0] cycle,
    input  tgc_qcfg_t   cfg,
    input  logic [31:0] dur,
    input  logic        len_ok,
    input  logic        live,
    output logic        gate,
    output logic        admit
);

    tgc_time_t finish;
    logic      in_win;
    logic      end_ok;
    logic      cyc_ok;

    always_comb begin
        finish = phase + 64'(dur);
        in_win = (phase >= 64'(cfg.start_ofs)) && (phase < 64'(cfg.end_ofs));
        end_ok = !cfg.strict_end || (finish <= 64'(cfg.end_ofs));
        cyc_ok = !cfg.strict_cyc || (finish <= 64'(cycle));
        gate   = live && in_win;
        admit  = gate && len_ok && end_ok && cyc_ok;
    end

endmodule

// File: rtl/tgc_cycle_track.sv
module tgc_cycle_track
    import tgc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  tgc_time_t   load_val,
    input  logic [31:0] cycle,
    input  tgc_time_t   now,
    input  logic        advance,
    output tgc_time_t   phase,
    output logic        started
);

    tgc_time_t cs_q;
    tgc_time_t raw;
    logic      wrap;

    always_comb begin
        raw     = now - cs_q;
        started = (now >= cs_q);
        wrap    = started && (raw >= 64'(cycle));
        phase   = wrap ? (raw - 64'(cycle)) : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '0;
        end else if (load) begin
            cs_q <= load_val;
        end else if (advance && wrap) begin
            cs_q <= cs_q + 64'(cycle);
        end
    end

endmodule

// File: rtl/tgc_rem_div.sv
module tgc_rem_div #(
    parameter int unsigned DW = 64,
    parameter int unsigned VW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          done,
    output logic [VW-1:0] rem
);

    localparam int unsigned CNT_W = $clog2(DW) + 1;

    logic [DW-1:0]    dvd_q;
    logic [VW-1:0]    dvs_q;
    logic [VW-1:0]    rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [VW:0]      trial;
    logic             fits;

    always_comb begin
        trial = {rem_q, dvd_q[DW-1]};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                dvd_q  <= dividend;
                dvs_q  <= divisor;
                rem_q  <= '0;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                dvd_q <= dvd_q << 1;
                rem_q <= fits ? VW'(trial - {1'b0, dvs_q}) : VW'(trial);
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(DW - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign rem  = rem_q;

endmodule

// File: rtl/tgc_gate_ctrl.sv
module tgc_gate_ctrl
    import tgc_pkg::*;
#(
    parameter int unsigned NQ      = 4,
    parameter int unsigned SEC_W   = 32,
    parameter int unsigned LEN_W   = 14,
    parameter int unsigned MAX_LEN = 1600
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEC_W-1:0]   tod_sec,
    input  logic [29:0]        tod_ns,
    input  logic               sched_en,
    input  logic [SEC_W-1:0]   base_sec,
    input  logic [29:0]        base_ns,
    input  logic [31:0]        cycle_ns,
    input  logic [NQ*32-1:0]   q_start,
    input  logic [NQ*32-1:0]   q_end,
    input  logic [NQ-1:0]      strict_cycle,
    input  logic [NQ-1:0]      strict_end,
    input  logic [LEN_W-1:0]   frame_len,
    output logic [NQ-1:0]      gate_open,
    output logic [NQ-1:0]      may_start,
    output logic [SEC_W-1:0]   eff_base_sec,
    output logic [29:0]        eff_base_ns
);

    localparam int unsigned TW    = 64;
    localparam int unsigned EXT_W = 34;

    tgc_state_e        state_q;
    logic [SEC_W-1:0]  snap_sec_q;
    logic [29:0]       snap_ns_q;
    logic [SEC_W-1:0]  eff_sec_q;
    logic [EXT_W-1:0]  eff_ns_q;
    logic [31:0]       cyc_q;
    tgc_qcfg_t         qcfg_q [NQ];

    tgc_time_t         now_t;
    tgc_time_t         base_t;
    logic              base_ahead;
    logic              div_start;
    logic              div_done;
    logic [31:0]       div_rem;
    logic              ns_over;
    logic              trk_load;
    tgc_time_t         trk_val;
    tgc_time_t         phase_t;
    logic              started;
    logic              live;
    logic [31:0]       dur_ns;
    logic              len_ok;
    logic [NQ-1:0]     gate_w;
    logic [NQ-1:0]     adm_w;
    logic [NQ-1:0]     gate_q;
    logic [NQ-1:0]     adm_q;

    always_comb begin
        now_t      = tgc_to_ns(32'(tod_sec), 32'(tod_ns));
        base_t     = tgc_to_ns(32'(base_sec), 32'(base_ns));
        base_ahead = (base_t >= now_t);
        div_start  = (state_q == ST_OFF) && sched_en && !base_ahead;
        ns_over    = (eff_ns_q >= EXT_W'(TGC_NS_PER_SEC));
        trk_load   = (state_q == ST_NORM) && sched_en && !ns_over;
        trk_val    = tgc_to_ns(32'(eff_sec_q), eff_ns_q[31:0]);
        live       = (state_q == ST_RUN) && started;
        dur_ns     = tgc_frame_ns(16'(frame_len));
        len_ok     = (32'(frame_len) <= MAX_LEN);
    end

    tgc_rem_div #(
        .DW (TW),
        .VW (32)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (now_t - base_t),
        .divisor  (cycle_ns),
        .done     (div_done),
        .rem      (div_rem)
    );

    tgc_cycle_track u_track (
        .clk      (clk),
        .rst      (rst),
        .load     (trk_load),
        .load_val (trk_val),
        .cycle    (cyc_q),
        .now      (now_t),
        .advance  (state_q == ST_RUN),
        .phase    (phase_t),
        .started  (started)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        tgc_qgate u_qgate (
            .phase  (phase_t),
            .cycle  (cyc_q),
            .cfg    (qcfg_q[g]),
            .dur    (dur_ns),
            .len_ok (len_ok),
            .live   (live),
            .gate   (gate_w[g]),
            .admit  (adm_w[g])
        );
    end

    // arming, forward move of the base and carry into seconds
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            snap_sec_q <= '0;
            snap_ns_q  <= '0;
            eff_sec_q  <= '0;
            eff_ns_q   <= '0;
            cyc_q      <= TGC_NS_PER_SEC;
            for (int i = 0; i < NQ; i++) begin
                qcfg_q[i] <= TGC_QCFG_DEFAULT;
            end
        end else begin
            case (state_q)
                ST_OFF: begin
                    if (sched_en) begin
                        cyc_q      <= cycle_ns;
                        snap_sec_q <= tod_sec;
                        snap_ns_q  <= tod_ns;
                        for (int i = 0; i < NQ; i++) begin
                            qcfg_q[i].start_ofs  <= q_start[i*32 +: 32];
                            qcfg_q[i].end_ofs    <= q_end[i*32 +: 32];
                            qcfg_q[i].strict_cyc <= strict_cycle[i];
                            qcfg_q[i].strict_end <= strict_end[i];
                        end
                        if (base_ahead) begin
                            eff_sec_q <= base_sec;
                            eff_ns_q  <= EXT_W'(base_ns);
                            state_q   <= ST_NORM;
                        end else begin
                            state_q   <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (!sched_en) begin
                        state_q <= ST_OFF;
                    end else if (div_done) begin
                        eff_sec_q <= snap_sec_q;
                        eff_ns_q  <= EXT_W'(snap_ns_q) + EXT_W'(cyc_q) - EXT_W'(div_rem);
                        state_q   <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (!sched_en) begin
                        state_q <= ST_OFF;
                    end else if (ns_over) begin
                        eff_ns_q  <= eff_ns_q - EXT_W'(TGC_NS_PER_SEC);
                        eff_sec_q <= eff_sec_q + 1'b1;
                    end else begin
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    if (!sched_en) begin
                        state_q <= ST_OFF;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '1;
            adm_q  <= '1;
        end else begin
            case (state_q)
                ST_OFF: begin
                    gate_q <= '1;
                    adm_q  <= '1;
                end
                ST_RUN: begin
                    gate_q <= gate_w;
                    adm_q  <= adm_w;
                end
                default: begin
                    gate_q <= '0;
                    adm_q  <= '0;
                end
            endcase
        end
    end

    assign gate_open    = gate_q;
    assign may_start    = adm_q;
    assign eff_base_sec = eff_sec_q;
    assign eff_base_ns  = eff_ns_q[29:0];

endmodule

// File: rtl/tgc_gate_ctrl_chk.sv
module tgc_gate_ctrl_chk
    import tgc_pkg::*;
#(
    parameter int unsigned NQ      = 4,
    parameter int unsigned SEC_W   = 32,
    parameter int unsigned LEN_W   = 14,
    parameter int unsigned MAX_LEN = 1600
) (
    input  logic             clk,
    input  logic             rst,
    input  tgc_state_e       state,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [NQ-1:0]    gate_open,
    input  logic [NQ-1:0]    may_start,
    input  logic [SEC_W-1:0] eff_base_sec,
    input  logic [29:0]      eff_base_ns
);

    // R1: schedule off means every gate open and every frame admitted
    a_r1_off_all_open: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) |=> ((&gate_open) && (&may_start)));

    // R5: nothing opens while the start time is being computed
    a_r5_closed_while_adjusting: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DIV) || (state == ST_NORM)) |=> ((gate_open == '0) && (may_start == '0)));

    // R4: effective nanoseconds stay below one second while running
    a_r4_ns_in_range: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (eff_base_ns < 30'd1_000_000_000));

    // R9: over-length frames refused while running
    a_r9_long_frame_refused: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && (32'(frame_len) > MAX_LEN)) |=> (may_start == '0));

    // R10: admission only through an open gate
    a_r10_admit_needs_gate: assert property (@(posedge clk) disable iff (rst)
        ((may_start & ~gate_open) == '0));

    // R11: the applied start time holds while the schedule runs
    a_r11_base_held: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && ($past(state) == ST_RUN)) |-> ($stable(eff_base_sec) && $stable(eff_base_ns)));

endmodule

bind tgc_gate_ctrl tgc_gate_ctrl_chk #(
    .NQ      (NQ),
    .SEC_W   (SEC_W),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (state_q),
    .frame_len    (frame_len),
    .gate_open    (gate_open),
    .may_start    (may_start),
    .eff_base_sec (eff_base_sec),
    .eff_base_ns  (eff_base_ns)
);

// File: tb/test_tgc_gate_ctrl.sv
module test_tgc_gate_ctrl;

    localparam int unsigned NQ    = 4;
    localparam int unsigned STEP  = 8;
    localparam int unsigned LAST  = 1000;

    typedef struct packed {
        logic [63:0]       arm_now;
        logic [31:0]       b_sec;
        logic [31:0]       b_ns;
        logic [31:0]       cyc;
        logic [0:3][31:0]  st;
        logic [0:3][31:0]  en;
        logic [3:0]        sc;
        logic [3:0]        se;
    } scn_t;

    localparam scn_t SCN [4] = '{
        // future base, no guards
        '{64'd5_000_000_100, 32'd5, 32'd3000, 32'd1000,
          '{32'd0, 32'd250, 32'd500, 32'd100}, '{32'd250, 32'd500, 32'd1000, 32'd900},
          4'b0000, 4'b0000},
        // past base, window-end guard on all queues
        '{64'd2_000_100_050, 32'd2, 32'd0, 32'd1000,
          '{32'd0, 32'd400, 32'd800, 32'd0}, '{32'd400, 32'd800, 32'd1000, 32'd1000},
          4'b0000, 4'b1111},
        // past base, move forward carries into seconds, cycle guard
        '{64'd3_999_999_900, 32'd3, 32'd999_999_000, 32'd3000,
          '{32'd0, 32'd1000, 32'd2000, 32'd500}, '{32'd1000, 32'd2000, 32'd3000, 32'd2500},
          4'b1111, 4'b0000},
        // future base whose ns field exceeds one second, mixed guards
        '{64'd7_999_999_000, 32'd7, 32'd1_000_000_500, 32'd2000,
          '{32'd0, 32'd600, 32'd1200, 32'd300}, '{32'd600, 32'd1200, 32'd2000, 32'd1700},
          4'b0101, 4'b0011}
    };

    localparam logic [13:0] LENS [8] = '{14'd64, 14'd100, 14'd300, 14'd1500,
                                         14'd1600, 14'd1601, 14'd9000, 14'd20};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [63:0]       now_t = 64'd1000;
    logic [31:0]       tod_sec;
    logic [29:0]       tod_ns;
    logic              sched_en = 1'b0;
    logic [31:0]       base_sec = '0;
    logic [29:0]       base_ns = '0;
    logic [31:0]       cycle_ns = 32'd1000;
    logic [NQ*32-1:0]  q_start = '0;
    logic [NQ*32-1:0]  q_end = '0;
    logic [NQ-1:0]     strict_cycle = '0;
    logic [NQ-1:0]     strict_end = '0;
    logic [13:0]       len_v = 14'd64;
    logic [NQ-1:0]     gate_open;
    logic [NQ-1:0]     may_start;
    logic [31:0]       eff_base_sec;
    logic [29:0]       eff_base_ns;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    assign tod_sec = 32'(now_t / 64'd1_000_000_000);
    assign tod_ns  = 30'(now_t % 64'd1_000_000_000);

    tgc_gate_ctrl i_tgc_gate_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tod_sec      (tod_sec),
        .tod_ns       (tod_ns),
        .sched_en     (sched_en),
        .base_sec     (base_sec),
        .base_ns      (base_ns),
        .cycle_ns     (cycle_ns),
        .q_start      (q_start),
        .q_end        (q_end),
        .strict_cycle (strict_cycle),
        .strict_end   (strict_end),
        .frame_len    (len_v),
        .gate_open    (gate_open),
        .may_start    (may_start),
        .eff_base_sec (eff_base_sec),
        .eff_base_ns  (eff_base_ns)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (time %0d)", tag, act, exp, now_t);
        end
    endtask

    // expected effective base from the arming rule
    function automatic longint unsigned model_base(input scn_t s);
        longint unsigned b;
        b = longint'(s.b_sec) * 64'd1_000_000_000 + longint'(s.b_ns);
        if (b >= s.arm_now) return b;
        return b + ((s.arm_now - b) / longint'(s.cyc) + 64'd1) * longint'(s.cyc);
    endfunction

    // expected {admit, gate} for a time and a length
    function automatic logic [7:0] model_out(input scn_t s, input longint unsigned now,
                                             input int unsigned len);
        longint unsigned eb;
        longint unsigned ph;
        longint unsigned dur;
        logic [3:0] g;
        logic [3:0] a;
        eb = model_base(s);
        if (now < eb) return 8'h00;
        ph  = (now - eb) % longint'(s.cyc);
        dur = (longint'(len) * 64'd32 + 64'd9) / 64'd10;
        for (int q = 0; q < 4; q++) begin
            g[q] = (ph >= longint'(s.st[q])) && (ph < longint'(s.en[q]));
            a[q] = g[q] && (len <= 1600)
                 && (!s.se[q] || (ph + dur <= longint'(s.en[q])))
                 && (!s.sc[q] || (ph + dur <= longint'(s.cyc)));
        end
        return {a, g};
    endfunction

    task automatic drive_cfg(input scn_t s);
        base_sec     = s.b_sec;
        base_ns      = 30'(s.b_ns);
        cycle_ns     = s.cyc;
        strict_cycle = s.sc;
        strict_end   = s.se;
        for (int q = 0; q < 4; q++) begin
            q_start[q*32 +: 32] = s.st[q];
            q_end[q*32 +: 32]   = s.en[q];
        end
    endtask

    task automatic scramble_cfg();
        base_sec     = '0;
        base_ns      = '0;
        cycle_ns     = 32'd777;
        strict_cycle = ~strict_cycle;
        strict_end   = ~strict_end;
        q_start      = '0;
        q_end        = {NQ{32'd5}};
    endtask

    initial begin
        #500_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic closed_ok;
        len_v = 14'd9000;
        repeat (2) @(negedge clk);
        // R1: reset state already open
        check("R1 gate in reset", 64'(gate_open), 64'hF);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 gate off", 64'(gate_open), 64'hF);
        check("R1 admit off long frame", 64'(may_start), 64'hF);

        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            rst = 1'b1;
            sched_en = 1'b0;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            now_t = SCN[s].arm_now;
            len_v = LENS[0];
            drive_cfg(SCN[s]);
            sched_en = 1'b1;
            closed_ok = 1'b1;
            for (int j = 1; j <= LAST; j++) begin
                @(negedge clk);
                if (j >= 2 && j <= 60) begin
                    if (gate_open != '0 || may_start != '0) closed_ok = 1'b0;
                end
                if (j == 60) check("R5 closed before start", 64'(closed_ok), 64'd1);
                if (j == 90) begin
                    check("R3 R4 eff seconds", 64'(eff_base_sec), model_base(SCN[s]) / 64'd1_000_000_000);
                    check("R3 R4 eff nanoseconds", 64'(eff_base_ns), model_base(SCN[s]) % 64'd1_000_000_000);
                end
                if (j > 90) begin
                    logic [7:0] e;
                    e = model_out(SCN[s], now_t, int'(len_v));
                    // R11: config inputs were changed after arming; latched schedule must persist
                    check("R2 R11 R12 gate", 64'(gate_open), 64'(e[3:0]));
                    check("R6 R7 R8 R9 R10 admit", 64'(may_start), 64'(e[7:4]));
                end
                now_t = now_t + STEP;
                len_v = LENS[j % 8];
                if (j == 3) scramble_cfg();
            end
        end

        // R1: dropping the enable restores the open default
        @(negedge clk);
        sched_en = 1'b0;
        len_v = 14'd9000;
        repeat (4) @(negedge clk);
        check("R1 gate after disable", 64'(gate_open), 64'hF);
        check("R1 admit after disable", 64'(may_start), 64'hF);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule